// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Show-Ahead Read

This block is a first-in first-out buffer that runs on one clock. Data width and depth are set by parameter; the depth must be a power of two. One elaboration-time parameter picks how reads behave. In the normal style, a read request loads the oldest word into the data output register, and that word appears one edge later. In the show-ahead style, the oldest word is already on the output while the buffer holds data, and a read request consumes it and moves on to the next word.

Separate parameters set whether a write to a full buffer and a read from an empty buffer are refused inside the block. Two clears are provided. The asynchronous clear acts at once, for a pulse of any width, and returns the whole buffer to its idle state. The synchronous clear empties the buffer at the next edge. In normal style it leaves the read data register alone. In show-ahead style the output falls to zero because the buffer is empty. A write request held across the release of the asynchronous clear is dropped on the first edge after the release, which removes the race between that release and the clock.

Top module: `showahead_fifo`

## Requirements
- R1: Words leave the buffer in exactly the order they were accepted, and the read data output is as wide as the write data input.
- R2: `level` equals the number of stored words, `full` is high exactly when `level` equals DEPTH, and `empty` is high exactly when `level` is 0.
- R3: With the write guard enabled, a write request while `full` is high is refused: `level` stays at DEPTH and the stored words are unchanged.
- R4: With the read guard enabled, a read request while `empty` is high is refused: `level` stays 0 and later data is not skipped.
- R5: In normal style, `rd_data` takes the oldest word on the clock edge that accepts a read and holds its value in every cycle without an accepted read.
- R6: In show-ahead style, `rd_data` shows the oldest stored word in every cycle the buffer is not empty and shows 0 while it is empty; an accepted read moves it to the next word on that edge.
- R7: A read and a write in the same cycle on a buffer that is neither empty nor full leave `level` unchanged; on an empty buffer only the write is accepted, so `level` becomes 1.
- R8: `sync_clr` high at an edge empties the buffer (`level` 0, `empty` 1, `full` 0) and overrides any read or write in that cycle; in normal style `rd_data` keeps its value, and in show-ahead style it becomes 0.
- R9: `async_clr` high, for any duration and without waiting for a clock edge, forces `level` to 0, `empty` to 1, `full` to 0 and `rd_data` to 0.
- R10: A write request at the first clock edge after `async_clr` falls is ignored; the same request at the next edge is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| async_clr | input | 1 | Asynchronous clear, active high |
| sync_clr | input | 1 | Synchronous clear, active high |
| wr_req | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_req | input | 1 | Read request |
| rd_data | output | WIDTH | Read data (registered in normal style, head word in show-ahead style) |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| level | output | $clog2(DEPTH)+1 | Number of stored words |

## Verification
Every accepted request shows up one edge later. `level`, `full` and `empty` change on the edge that samples the request. Normal-style `rd_data` loads on that same edge, and show-ahead `rd_data` follows the new head within that cycle. The bench drives its inputs on the falling edge and steps a queue-based model on each rising edge. It compares both a normal-style and a show-ahead instance with the model at the following falling edge, so each result is checked exactly one edge after its stimulus. The asynchronous clear is the one exception: it is checked while the pulse is still high, with no edge in between. The release rule is checked at the first falling edge after release and again at the second.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic {
        RD_NORMAL     = 1'b0,
        RD_SHOW_AHEAD = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/sfifo_ctrl.sv
// Pointer, count and guard logic of the buffer.
module sfifo_ctrl #(
    parameter int DEPTH    = 16,
    parameter bit GUARD_WR = 1'b1,
    parameter bit GUARD_RD = 1'b1,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          async_clr,
    input  logic          sync_clr,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
        logic          blk;   // drop writes on first edge after async clear
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        full  = (st_q.count == CW'(DEPTH));
        empty = (st_q.count == '0);
        wr_ok = wr_req && !sync_clr && !st_q.blk && !(GUARD_WR && full);
        rd_ok = rd_req && !sync_clr && !(GUARD_RD && empty);

        st_d     = st_q;
        st_d.blk = 1'b0;
        if (sync_clr) begin
            st_d.wptr  = '0;
            st_d.rptr  = '0;
            st_d.count = '0;
        end else begin
            if (wr_ok) st_d.wptr = st_q.wptr + 1'b1;
            if (rd_ok) st_d.rptr = st_q.rptr + 1'b1;
            st_d.count = st_q.count + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    always_ff @(posedge clk or posedge async_clr) begin
        if (async_clr) st_q <= '{wptr: '0, rptr: '0, count: '0, blk: 1'b1};
        else           st_q <= st_d;
    end

    assign wr_addr = st_q.wptr;
    assign rd_addr = st_q.rptr;
    assign level   = st_q.count;
endmodule

// File: rtl/sfifo_store.sv
// Word storage: one write port, one combinational read port.
module sfifo_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sfifo_out.sv
// Read data stage; the read style picks the variant.
module sfifo_out #(
    parameter int                  WIDTH   = 8,
    parameter sfifo_pkg::rd_mode_e RD_MODE = sfifo_pkg::RD_NORMAL
) (
    input  logic             clk,
    input  logic             async_clr,
    input  logic             rd_ok,
    input  logic             empty,
    input  logic [WIDTH-1:0] head,
    output logic [WIDTH-1:0] rd_data
);
    if (RD_MODE == sfifo_pkg::RD_SHOW_AHEAD) begin : g_show_ahead
        // Head word is visible directly; zero while nothing is stored.
        assign rd_data = empty ? '0 : head;
        logic unused_sa;
        assign unused_sa = ^{clk, async_clr, rd_ok};
    end else begin : g_normal
        logic [WIDTH-1:0] data_d, data_q;

        always_comb begin
            data_d = data_q;
            if (rd_ok) data_d = head;
        end

        always_ff @(posedge clk or posedge async_clr) begin
            if (async_clr) data_q <= '0;
            else           data_q <= data_d;
        end

        assign rd_data = data_q;
        logic unused_nm;
        assign unused_nm = empty;
    end
endmodule

// File: rtl/showahead_fifo.sv
module showahead_fifo #(
    parameter int                  WIDTH    = 8,
    parameter int                  DEPTH    = 16,
    parameter sfifo_pkg::rd_mode_e RD_MODE  = sfifo_pkg::RD_NORMAL,
    parameter bit                  GUARD_WR = 1'b1,
    parameter bit                  GUARD_RD = 1'b1
) (
    input  logic                     clk,
    input  logic                     async_clr,
    input  logic                     sync_clr,
    input  logic                     wr_req,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     rd_req,
    output logic [WIDTH-1:0]         rd_data,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);

    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [WIDTH-1:0] head;

    sfifo_ctrl #(
        .DEPTH    (DEPTH),
        .GUARD_WR (GUARD_WR),
        .GUARD_RD (GUARD_RD)
    ) i_ctrl (
        .clk       (clk),
        .async_clr (async_clr),
        .sync_clr  (sync_clr),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .wr_ok     (wr_ok),
        .rd_ok     (rd_ok),
        .wr_addr   (wr_addr),
        .rd_addr   (rd_addr),
        .level     (level),
        .full      (full),
        .empty     (empty)
    );

    sfifo_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
    ) i_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (head)
    );

    sfifo_out #(
        .WIDTH   (WIDTH),
        .RD_MODE (RD_MODE)
    ) i_out (
        .clk       (clk),
        .async_clr (async_clr),
        .rd_ok     (rd_ok),
        .empty     (empty),
        .head      (head),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/sfifo_sva.sv
module sfifo_sva #(
    parameter int                  WIDTH    = 8,
    parameter int                  DEPTH    = 16,
    parameter sfifo_pkg::rd_mode_e RD_MODE  = sfifo_pkg::RD_NORMAL,
    parameter bit                  GUARD_WR = 1'b1,
    parameter bit                  GUARD_RD = 1'b1,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             async_clr,
    input logic             sync_clr,
    input logic             wr_req,
    input logic             rd_req,
    input logic [WIDTH-1:0] rd_data,
    input logic             full,
    input logic             empty,
    input logic [CW-1:0]    level
);
    p_flags_excl_r2: assert property (@(posedge clk) disable iff (async_clr)
        !(full && empty));

    p_sclr_r8: assert property (@(posedge clk) disable iff (async_clr)
        sync_clr |=> (empty && !full && level == '0));

    p_both_r7: assert property (@(posedge clk) disable iff (async_clr)
        (wr_req && rd_req && !full && !empty && !sync_clr) |=> $stable(level));

    p_release_r10: assert property (@(posedge clk) disable iff (async_clr)
        (!async_clr && $past(async_clr)) |=> (level == '0));

    if (GUARD_WR && GUARD_RD) begin : g_bound
        p_level_bound_r2: assert property (@(posedge clk) disable iff (async_clr)
            level <= CW'(DEPTH));
    end

    if (GUARD_WR) begin : g_wr_guard
        p_no_overflow_r3: assert property (@(posedge clk) disable iff (async_clr)
            (full && wr_req && !rd_req && !sync_clr) |=> (full && $stable(level)));
    end

    if (GUARD_RD) begin : g_rd_guard
        p_no_underflow_r4: assert property (@(posedge clk) disable iff (async_clr)
            (empty && rd_req && !wr_req && !sync_clr) |=> empty);
    end

    if (RD_MODE == sfifo_pkg::RD_SHOW_AHEAD) begin : g_sa
        p_sa_empty_zero_r6: assert property (@(posedge clk) disable iff (async_clr)
            empty |-> (rd_data == '0));
    end else begin : g_nm
        p_nm_hold_r5: assert property (@(posedge clk) disable iff (async_clr)
            !rd_req |=> $stable(rd_data));
    end
endmodule

bind showahead_fifo sfifo_sva #(
    .WIDTH    (WIDTH),
    .DEPTH    (DEPTH),
    .RD_MODE  (RD_MODE),
    .GUARD_WR (GUARD_WR),
    .GUARD_RD (GUARD_RD)
) i_sfifo_sva (
    .clk       (clk),
    .async_clr (async_clr),
    .sync_clr  (sync_clr),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .rd_data   (rd_data),
    .full      (full),
    .empty     (empty),
    .level     (level)
);

// File: tb/test_showahead_fifo.sv
`timescale 1ns/1ps
module test_showahead_fifo;
    localparam int W  = 8;
    localparam int D  = 16;
    localparam int LW = $clog2(D) + 1;

    logic clk = 1'b0;
    logic aclr = 1'b1, sclr = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dn, ds;
    logic fn, en, fs, es;
    logic [LW-1:0] ln, ls;

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    showahead_fifo #(.WIDTH(W), .DEPTH(D), .RD_MODE(sfifo_pkg::RD_NORMAL)) i_showahead_fifo (
        .clk(clk), .async_clr(aclr), .sync_clr(sclr), .wr_req(wr), .wr_data(din),
        .rd_req(rd), .rd_data(dn), .full(fn), .empty(en), .level(ln));

    showahead_fifo #(.WIDTH(W), .DEPTH(D), .RD_MODE(sfifo_pkg::RD_SHOW_AHEAD)) i_showahead_fifo_sa (
        .clk(clk), .async_clr(aclr), .sync_clr(sclr), .wr_req(wr), .wr_data(din),
        .rd_req(rd), .rd_data(ds), .full(fs), .empty(es), .level(ls));

    // Reference model
    logic [W-1:0] mq[$];
    logic [W-1:0] m_norm;
    bit m_blk;

    always @(posedge clk or posedge aclr) begin
        if (aclr) begin
            mq.delete();
            m_norm = '0;
            m_blk  = 1'b1;
        end else begin
            if (sclr) begin
                mq.delete();
            end else begin
                automatic bit w = wr && !m_blk && (mq.size() < D);
                automatic bit r = rd && (mq.size() > 0);
                if (r) begin
                    m_norm = mq[0];
                    void'(mq.pop_front());
                end
                if (w) mq.push_back(din);
            end
            m_blk = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !aclr && !done) begin
            automatic int sz = mq.size();
            automatic logic [W-1:0] sa_exp = (sz > 0) ? mq[0] : '0;
            chk(ln == LW'(sz) && ls == LW'(sz), "R2 level", {ln, ls}, sz);
            chk(fn == (sz == D) && en == (sz == 0) && fs == fn && es == en,
                "R2 flags", {fn, en, fs, es}, sz);
            chk(dn == m_norm, "R1/R5 normal rd_data", dn, m_norm);
            chk(ds == sa_exp, "R1/R6 show-ahead rd_data", ds, sa_exp);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        int bias;
        repeat (3) step();
        aclr = 1'b0;
        step();
        cmp_en = 1'b1;
        // reset state, R9
        chk(ln == 0 && en && !fn && dn == 0 && ds == 0, "R9 reset state", {ln, en, fn}, 'h1);

        // preload three words
        wr = 1'b1;
        for (int i = 0; i < 3; i++) begin din = W'(8'h10 + i); step(); end
        wr = 1'b0;
        step();
        chk(ln == 3, "R2 preload level", ln, 3);

        // short async pulse with write held across release: R9, R10
        wr = 1'b1; din = 8'h55;
        #1 aclr = 1'b1;
        #0.5;
        chk(ln == 0 && ls == 0 && en && !fn && dn == 0 && ds == 0,
            "R9 async clear mid-cycle", ln, 0);
        #0.5 aclr = 1'b0;
        step();
        chk(ln == 0, "R10 first edge after release ignores write", ln, 0);
        step();
        chk(ln == 1 && ds == 8'h55, "R10 second edge accepts write", {ln, ds}, {5'd1, 8'h55});
        chk(ds == 8'h55, "R6 head visible without read", ds, 8'h55);

        // fill to full
        for (int i = 1; i < D; i++) begin din = W'(8'h60 + i); step(); end
        chk(fn && ln == D, "R2 full at DEPTH", ln, D);
        // write while full: R3
        din = 8'hEE; step(); step();
        chk(fn && ln == D, "R3 write while full refused", ln, D);
        wr = 1'b0;

        // drain; model checks order of data (R1)
        rd = 1'b1;
        step();
        chk(dn == 8'h55, "R5 first read loads oldest", dn, 8'h55);
        while (!en) step();
        step(); step();
        chk(en && ln == 0, "R4 read while empty refused", ln, 0);
        // read+write on empty: R7
        wr = 1'b1; din = 8'hA1;
        step();
        chk(ln == 1, "R7 empty read+write accepts write only", ln, 1);
        din = 8'hA2; step();
        din = 8'hA3; step();
        chk(ln == 1 && ds == 8'hA3, "R7 read+write keeps level", {ln, ds}, {5'd1, 8'hA3});
        chk(dn == 8'hA2, "R4 no data skipped after empty reads", dn, 8'hA2);
        rd = 1'b0;
        din = 8'hA4; step();
        wr = 1'b0;

        // sync clear with read and write pending: R8
        held = dn;
        sclr = 1'b1; wr = 1'b1; rd = 1'b1; din = 8'hBB;
        step();
        sclr = 1'b0; wr = 1'b0; rd = 1'b0;
        chk(ln == 0 && en && !fn, "R8 sync clear empties", ln, 0);
        chk(dn == held, "R8 normal rd_data kept", dn, held);
        chk(ds == 0, "R8 show-ahead rd_data zero", ds, 0);
        step();

        // random traffic
        bias = 50;
        for (int c = 0; c < 3000; c++) begin
            if (c % 200 == 0) bias = (c / 200) % 3 == 0 ? 80 : ((c / 200) % 3 == 1 ? 20 : 50);
            wr   = ($urandom % 100) < bias;
            rd   = ($urandom % 100) < (100 - bias);
            din  = W'($urandom);
            sclr = ($urandom % 150) == 0;
            step();
        end
        wr = 1'b0; rd = 1'b0; sclr = 1'b0;
        step();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule